// File: doc/BRIEF.md
# AES Fused Substitute-and-Mix Execute Unit

This execute unit speeds up the round function of AES encryption inside a 32-bit processor datapath. It joins the byte substitution (S-box) and the column-mixing multiplication into one operation. The substitution is always applied first, and the mixing arithmetic works on its output. One issue strobe starts an operation. The result is registered, and a done pulse follows one cycle later.

The unit has two modes. In byte mode the caller supplies a source word and a 2-bit index. A byte rotator brings the indexed byte to the front, and that byte is substituted. The unit then returns a 32-bit word that holds the four contributions this one byte makes to the mixed column, placed in the rows that match its position. Software can XOR four such words, one for each byte, to build a full mixed column. In word mode the unit substitutes all four bytes of one column and mixes the whole column in a single step. The caller writes the result back over the same register.

A test input bypasses the substitution stage, so that known mixing vectors can be applied directly.

Top module: `smix_unit`

## Requirements
- R1: While reset is asserted, and until the first issue, `result_o` is zero and `done_o` is low.
- R2: `done_o` is high for exactly the one cycle after each cycle in which `issue_i` is sampled high, and is low at all other times.
- R3: `result_o` changes only on an issue. With `issue_i` low it holds its value, whatever the other inputs do.
- R4: With the bypass low, each byte passes through the AES forward S-box before any mixing, so that, for example, 0x00 maps to 0x63 and 0x53 maps to 0xED.
- R5: In word mode (`word_mode_i`=1), row r of the result, with row r in bits [8r+7:8r], is 2·a[r] ^ 3·a[(r+1)%4] ^ a[(r+2)%4] ^ a[(r+3)%4] over the substituted bytes a. With the bypass high, column {db,13,53,45} in rows 0..3 gives {8e,4d,a1,bc}.
- R6: In byte mode (`word_mode_i`=0), the byte s is taken from row `idx_i` of `src_i`. The result is the column {2s, s, s, 3s} for rows 0..3, moved up by `idx_i` rows with wrap-around, so that row `idx_i` holds 2s.
- R7: In byte mode, the source bytes outside row `idx_i` have no effect on the result.
- R8: Multiplication by 2 is a left shift that is XORed with 0x1B when bit 7 of its input is set. Byte 0x80 at index 0 with the bypass high gives 0x9B80801B.
- R9: For any source word, the XOR of the four byte-mode results for indices 0 to 3 equals the word-mode result for that word.
- R10: In word mode, `idx_i` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| issue_i | input | 1 | Starts an operation in the cycle it is sampled high |
| word_mode_i | input | 1 | 1 selects whole-column mode, 0 selects single-byte mode |
| idx_i | input | 2 | Row of the source byte in byte mode |
| sbox_bypass_i | input | 1 | Test mode: skips the substitution stage |
| src_i | input | 32 | Source word, row r in bits [8r+7:8r] |
| result_o | output | 32 | Registered result, row r in bits [8r+7:8r] |
| done_o | output | 1 | One-cycle pulse that marks a new result |

## Verification
The bench applies the published mixing vector with the bypass high. It then compares every index against the others and against word mode, so that a rotator turning the wrong way, or a 2 and a 3 coefficient swapped, breaks the agreement that R9 requires. Byte 0x80 is used to test the reduction step: a multiply without the 0x1B fold would return 0x00 in place of 0x1B. A source word filled with unrelated bytes outside the selected row would expose a byte mode that reads the wrong row or mixes in the other rows. Idle cycles with a changing source would expose a result register that is missing its enable, and the done pulse is checked for both a missing pulse and a stretched one.

// File: rtl/smix_pkg.sv
package smix_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = LANE_W * LANES;
  localparam int IDX_W  = $clog2(LANES);

  // multiply by 2 modulo the AES field polynomial
  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] t;
    acc = 8'h00;
    t   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ t;
      t = gf_dbl(t);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254 (zero maps to zero)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] base;
    logic [7:0] e;
    r    = 8'h01;
    base = a;
    e    = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  function automatic logic [7:0] fwd_sbox(input logic [7:0] a);
    logic [7:0] b;
    b = gf_inv(a);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction
endpackage

// File: rtl/smix_lane_rot.sv
module smix_lane_rot #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter bit TOWARD_HIGH = 1'b1
) (
  input  logic [LANES*LANE_W-1:0]     word_i,
  input  logic [$clog2(LANES)-1:0]    amt_i,
  output logic [LANES*LANE_W-1:0]     word_o
);
  localparam int AW = $clog2(LANES);

  generate
    for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [AW-1:0] src_lane;
      if (TOWARD_HIGH) begin : g_up
        assign src_lane = AW'(j) - amt_i;
      end else begin : g_down
        assign src_lane = AW'(j) + amt_i;
      end
      assign word_o[j*LANE_W +: LANE_W] = word_i[src_lane*LANE_W +: LANE_W];
    end
  endgenerate
endmodule

// File: rtl/smix_sub_lane.sv
module smix_sub_lane (
  input  logic [7:0] byte_i,
  input  logic       bypass_i,
  output logic [7:0] byte_o
);
  import smix_pkg::*;
  assign byte_o = bypass_i ? byte_i : fwd_sbox(byte_i);
endmodule

// File: rtl/smix_col_mix.sv
module smix_col_mix #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] col_i,
  output logic [LANES*LANE_W-1:0] col_o
);
  import smix_pkg::*;
  logic [LANE_W-1:0] all_x;

  always_comb begin
    all_x = '0;
    for (int k = 0; k < LANES; k++) all_x = all_x ^ col_i[k*LANE_W +: LANE_W];
  end

  generate
    for (genvar r = 0; r < LANES; r++) begin : g_row
      logic [LANE_W-1:0] cur, nxt;
      assign cur = col_i[r*LANE_W +: LANE_W];
      assign nxt = col_i[((r + 1) % LANES)*LANE_W +: LANE_W];
      // a[r] ^ total leaves the three other rows; adding 2(a[r]^a[r+1]) gives 2,3,1,1
      assign col_o[r*LANE_W +: LANE_W] = cur ^ all_x ^ gf_dbl(cur ^ nxt);
    end
  endgenerate
endmodule

// File: rtl/smix_unit.sv
module smix_unit
  import smix_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic              word_mode_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              sbox_bypass_i,
  input  logic [WORD_W-1:0] src_i,
  output logic [WORD_W-1:0] result_o,
  output logic              done_o
);
  logic [IDX_W-1:0]  align_amt;
  logic [WORD_W-1:0] aligned;
  logic [WORD_W-1:0] subst;
  logic [WORD_W-1:0] mixed;
  logic [WORD_W-1:0] byte_col;
  logic [WORD_W-1:0] spread;
  logic [WORD_W-1:0] result_nxt;
  logic              done_nxt;
  logic [LANE_W-1:0] s0, s0x2;

  // byte mode pulls the chosen row down to row 0; word mode leaves the column as is
  assign align_amt = word_mode_i ? '0 : idx_i;

  smix_lane_rot #(.LANES(LANES), .LANE_W(LANE_W), .TOWARD_HIGH(1'b0)) u_align (
    .word_i (src_i),
    .amt_i  (align_amt),
    .word_o (aligned)
  );

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_sub
      smix_sub_lane u_sub (
        .byte_i   (aligned[l*LANE_W +: LANE_W]),
        .bypass_i (sbox_bypass_i),
        .byte_o   (subst[l*LANE_W +: LANE_W])
      );
    end
  endgenerate

  smix_col_mix #(.LANES(LANES), .LANE_W(LANE_W)) u_mix (
    .col_i (subst),
    .col_o (mixed)
  );

  // contributions of one byte to rows 0..3: {2s, s, s, 3s}
  assign s0       = subst[LANE_W-1:0];
  assign s0x2     = gf_dbl(s0);
  assign byte_col = {s0x2 ^ s0, s0, s0, s0x2};

  smix_lane_rot #(.LANES(LANES), .LANE_W(LANE_W), .TOWARD_HIGH(1'b1)) u_spread (
    .word_i (byte_col),
    .amt_i  (idx_i),
    .word_o (spread)
  );

  // next-state
  always_comb begin
    result_nxt = result_o;
    done_nxt   = 1'b0;
    if (issue_i) begin
      result_nxt = word_mode_i ? mixed : spread;
      done_nxt   = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      result_o <= result_nxt;
      done_o   <= done_nxt;
    end
  end

  a_r2_done_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> done_o);
  a_r2_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(issue_i));
  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> $stable(result_o));
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!done_o && result_o == '0));

  // R6: moving the column between rows must keep every bit
  always_comb begin
    if (rst_n && !$isunknown(byte_col) && !$isunknown(idx_i)) begin
      a_r6_spread_keeps_bits: assert ($countones(spread) == $countones(byte_col));
    end
  end
endmodule

// File: tb/tb_smix_unit.sv
module tb_smix_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_i;
  logic        word_mode_i;
  logic [1:0]  idx_i;
  logic        sbox_bypass_i;
  logic [31:0] src_i;
  logic [31:0] result_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  smix_unit dut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .word_mode_i(word_mode_i),
    .idx_i(idx_i), .sbox_bypass_i(sbox_bypass_i), .src_i(src_i),
    .result_o(result_o), .done_o(done_o)
  );

  // ---- reference model built from the requirements ----
  function automatic logic [7:0] m2(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction

  function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= t;
      t = m2(t);
    end
    return p;
  endfunction

  function automatic logic [7:0] ref_sbox(input logic [7:0] a);
    logic [7:0] inv = 8'h00;
    logic [7:0] o;
    for (int y = 1; y < 256; y++) if (mul(a, 8'(y)) == 8'h01) inv = 8'(y);
    for (int i = 0; i < 8; i++)
      o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ 8'h63 >> i;
    return o;
  endfunction

  function automatic logic [7:0] sub(input logic [7:0] a, input logic byp);
    return byp ? a : ref_sbox(a);
  endfunction

  function automatic logic [31:0] ref_byte(input logic [31:0] w, input int idx, input logic byp);
    logic [7:0] s;
    logic [7:0] col [4];
    logic [31:0] o;
    s = sub(w[8*idx +: 8], byp);
    col[0] = m2(s); col[1] = s; col[2] = s; col[3] = m2(s) ^ s;
    for (int r = 0; r < 4; r++) o[8*((r+idx)%4) +: 8] = col[r];
    return o;
  endfunction

  function automatic logic [31:0] ref_word(input logic [31:0] w, input logic byp);
    logic [7:0] a [4];
    logic [31:0] o;
    for (int r = 0; r < 4; r++) a[r] = sub(w[8*r +: 8], byp);
    for (int r = 0; r < 4; r++)
      o[8*r +: 8] = m2(a[r]) ^ m2(a[(r+1)%4]) ^ a[(r+1)%4] ^ a[(r+2)%4] ^ a[(r+3)%4];
    return o;
  endfunction

  // ---- helpers ----
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic wm, input logic [1:0] ix, input logic byp,
                       input logic [31:0] w, output logic [31:0] res);
    @(negedge clk);
    issue_i = 1'b1; word_mode_i = wm; idx_i = ix; sbox_bypass_i = byp; src_i = w;
    @(negedge clk);
    issue_i = 1'b0;
    check("R2 done pulse", {31'd0, done_o}, 32'd1);
    res = result_o;
    @(negedge clk);
    check("R2 done drops", {31'd0, done_o}, 32'd0);
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    check("R1 reset result", result_o, 32'h0);
    check("R1 reset done", {31'd0, done_o}, 32'd0);
  endtask

  task automatic t_vector();
    logic [31:0] r;
    issue(1'b1, 2'd0, 1'b1, 32'h455313db, r);
    check("R5 mix vector", r, 32'hbca14d8e);
    issue(1'b1, 2'd3, 1'b1, 32'h455313db, r);
    check("R10 idx ignored in word mode", r, 32'hbca14d8e);
  endtask

  task automatic t_sbox();
    logic [31:0] r;
    issue(1'b0, 2'd0, 1'b0, 32'h00000000, r);
    check("R4 sbox(00)", r, 32'ha56363c6);
    issue(1'b0, 2'd2, 1'b0, 32'h00530000, r);
    check("R4 sbox(53)", r, ref_byte(32'h00530000, 2, 1'b0));
    check("R4 sbox(53)=ed", {24'd0, r[23:16]}, {24'd0, m2(8'hed)});
  endtask

  task automatic t_xtime();
    logic [31:0] r;
    issue(1'b0, 2'd0, 1'b1, 32'h00000080, r);
    check("R8 reduction", r, 32'h9b80801b);
  endtask

  task automatic t_rotate();
    logic [31:0] r;
    for (int i = 0; i < 4; i++) begin
      issue(1'b0, 2'(i), 1'b1, 32'h80808080 ^ (32'h57 << (8*i)), r);
      check("R6 byte rotation", r, ref_byte(32'h80808080 ^ (32'h57 << (8*i)), i, 1'b1));
    end
  endtask

  task automatic t_ignore();
    logic [31:0] r;
    issue(1'b0, 2'd1, 1'b0, 32'hdeadc0fe, r);
    check("R7 other rows ignored", r, ref_byte(32'h0000c000, 1, 1'b0));
  endtask

  task automatic t_combine(input logic [31:0] w, input logic byp);
    logic [31:0] acc, r, wr;
    acc = 32'h0;
    for (int i = 0; i < 4; i++) begin
      issue(1'b0, 2'(i), byp, w, r);
      acc ^= r;
    end
    issue(1'b1, 2'd0, byp, w, wr);
    check("R9 byte sum equals word", acc, wr);
    check("R5 word result", wr, ref_word(w, byp));
  endtask

  task automatic t_hold();
    logic [31:0] r;
    issue(1'b1, 2'd0, 1'b0, 32'h01234567, r);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      src_i = 32'hffff0000 + 32'(c); word_mode_i = c[0]; idx_i = 2'(c);
      check("R3 result holds", result_o, r);
      check("R2 no done when idle", {31'd0, done_o}, 32'd0);
    end
  endtask

  initial begin
    rst_n = 1'b0; issue_i = 1'b0; word_mode_i = 1'b0; idx_i = 2'd0;
    sbox_bypass_i = 1'b0; src_i = 32'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_vector();
    t_sbox();
    t_xtime();
    t_rotate();
    t_ignore();
    t_combine(32'h455313db, 1'b1);
    t_combine(32'hd4bf5d30, 1'b0);
    t_combine(32'h0f1e2d3c, 1'b0);
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule